// File: doc/BRIEF.md
# Glitch-Safe Register Clear Pulse Generator

This block produces the short pulse that clears processor registers, such as the opcode register, during a storage read. Three inputs feed it. The first is a gating level that stays put for long stretches. The second is a cycle-state signal that can arrive late. The third is a read trigger that is active while a storage read is selected. The block runs on a fast clock, and one machine cycle spans 14 of its ticks.

When two machine states overlap for an instant at a state boundary, the cycle-state input can show a one-tick blip. That blip lines up with the rising edge of the trigger. Two measures keep it out of the clear pulse:

- The trigger passes through a one-tick delay stage before the three-input AND. A blip that coincides with the trigger edge therefore meets a trigger that is still low.
- The AND result does not drive the output directly. A rising-edge one-shot follows the AND and emits a pulse of fixed length. The extra tick of delay therefore never stretches the clear.

A later rise of the condition fires again only after the condition has been seen low.

Top module: `gsr_clear_pulse`

## Requirements
- R1: `reg_clear_o` rises only after a clock edge at which `gate_level_i` and `cycle_state_i` were both high and the trigger seen through the delay stage was high. That is, `read_trig_i` was high one edge earlier.
- R2: The trigger is delayed by DELAY_TICKS (default 1) clocks. Suppose all three inputs go high together before edge n, after a quiet period. Then `reg_clear_o` is still low after edge n and is high after edge n+1.
- R3: Consider a one-tick high on `cycle_state_i` that coincides with the first tick of `read_trig_i` high, with `cycle_state_i` low afterwards. It produces no clear pulse.
- R4: Every clear pulse lasts exactly PULSE_TICKS (default 2) clocks, whether the condition is high for one tick or for many.
- R5: A condition held high does not fire a second pulse. A new pulse needs the condition to be sampled low at or after the last clock of the previous pulse, and then high again.
- R6: A rising edge of the condition while a pulse is running neither restarts nor extends that pulse.
- R7: `rst_i` is synchronous and active high. It clears the delay stage and the one-shot. `reg_clear_o` is low after any edge with `rst_i` high, including in the middle of a pulse. A trigger held through reset counts only from the first edge after release.
- R8: The pulse is shorter than one machine cycle of MACHINE_TICKS (default 14) clocks. A parameter set with PULSE_TICKS of zero or at least MACHINE_TICKS is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock, MACHINE_TICKS per machine cycle |
| rst_i | input | 1 | Synchronous reset, active high |
| gate_level_i | input | 1 | Long-lived gating level |
| cycle_state_i | input | 1 | Late-arriving cycle-state level |
| read_trig_i | input | 1 | Storage-read trigger, active while storage select is on |
| reg_clear_o | output | 1 | Registered register-clear pulse |

## Verification
The assertions assume that the three inputs are synchronous levels that change only between clock edges. They also assume that reset is held for at least one edge before the block is used, so that the two-edge look back at the trigger never reaches into a period before reset.

The bench drives every input at the falling clock edge. It starts each run under reset. It then runs sweeps in which all 256 eight-tick patterns of the cycle-state input, and then of the gating level, are laid against a fixed trigger window inside one 14-tick machine cycle. The result is compared with an arithmetic per-tick expectation of pulse start, length and rearm.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    // Phases of the edge-triggered one-shot
    typedef enum logic [1:0] {
        OS_ARMED  = 2'd0,   // waiting for the condition to rise
        OS_FIRING = 2'd1,   // pulse is being emitted
        OS_SPENT  = 2'd2    // pulse done, condition still high
    } os_phase_e;

    // Bits needed to hold a down-counter starting at n-1
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/gsr_trig_delay.sv
module gsr_trig_delay #(
    parameter int unsigned DELAY_TICKS = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic trig_i,
    output logic trig_o
);

    generate
        if (DELAY_TICKS == 0) begin : g_bypass
            assign trig_o = trig_i;
        end else begin : g_pipe
            typedef struct packed {
                logic [DELAY_TICKS-1:0] pipe;
            } dly_t;

            dly_t dly_d, dly_q;

            always_comb begin
                dly_d      = dly_q;
                dly_d.pipe = DELAY_TICKS'({dly_q.pipe, trig_i});
            end

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    dly_q <= '0;
                end else begin
                    dly_q <= dly_d;
                end
            end

            assign trig_o = dly_q.pipe[DELAY_TICKS-1];
        end
    endgenerate

endmodule

// File: rtl/gsr_reset_cond.sv
module gsr_reset_cond (
    input  logic gate_i,
    input  logic state_i,
    input  logic trig_i,
    output logic cond_o
);

    always_comb begin
        cond_o = gate_i & state_i & trig_i;
    end

endmodule

// File: rtl/gsr_oneshot.sv
module gsr_oneshot
    import gsr_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cond_i,
    output logic pulse_o
);

    localparam int unsigned CW = cnt_bits(PULSE_TICKS);
    localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

    typedef struct packed {
        os_phase_e      phase;
        logic [CW-1:0]  left;
        logic           pulse;
    } os_t;

    os_t os_d, os_q;

    always_comb begin
        os_d = os_q;
        unique case (os_q.phase)
            OS_ARMED: begin
                if (cond_i) begin
                    os_d.phase = OS_FIRING;
                    os_d.left  = LAST;
                end
            end
            OS_FIRING: begin
                if (os_q.left == '0) begin
                    os_d.phase = cond_i ? OS_SPENT : OS_ARMED;
                end else begin
                    os_d.left = os_q.left - 1'b1;
                end
            end
            OS_SPENT: begin
                if (!cond_i) begin
                    os_d.phase = OS_ARMED;
                end
            end
            default: begin
                os_d.phase = OS_ARMED;
                os_d.left  = '0;
            end
        endcase
        os_d.pulse = (os_d.phase == OS_FIRING);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            os_q <= '{phase: OS_ARMED, left: '0, pulse: 1'b0};
        end else begin
            os_q <= os_d;
        end
    end

    assign pulse_o = os_q.pulse;

endmodule

// File: rtl/gsr_clear_pulse.sv
module gsr_clear_pulse #(
    parameter int unsigned DELAY_TICKS   = 1,
    parameter int unsigned PULSE_TICKS   = 2,
    parameter int unsigned MACHINE_TICKS = 14
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic gate_level_i,
    input  logic cycle_state_i,
    input  logic read_trig_i,
    output logic reg_clear_o
);

    // R8: pulse must fit inside one machine cycle
    generate
        if (PULSE_TICKS == 0 || PULSE_TICKS >= MACHINE_TICKS) begin : g_bad_cfg
            $error("gsr_clear_pulse: PULSE_TICKS must be in 1..MACHINE_TICKS-1");
        end
    endgenerate

    logic trig_dly;
    logic cond;

    gsr_trig_delay #(
        .DELAY_TICKS (DELAY_TICKS)
    ) u_dly (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .trig_i (read_trig_i),
        .trig_o (trig_dly)
    );

    gsr_reset_cond u_cond (
        .gate_i  (gate_level_i),
        .state_i (cycle_state_i),
        .trig_i  (trig_dly),
        .cond_o  (cond)
    );

    gsr_oneshot #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_os (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .cond_i  (cond),
        .pulse_o (reg_clear_o)
    );

endmodule

// File: rtl/gsr_clear_pulse_chk.sv
module gsr_clear_pulse_chk #(
    parameter int unsigned DELAY_TICKS   = 1,
    parameter int unsigned PULSE_TICKS   = 2,
    parameter int unsigned MACHINE_TICKS = 14
) (
    input logic clk_i,
    input logic rst_i,
    input logic gate_level_i,
    input logic cycle_state_i,
    input logic read_trig_i,
    input logic reg_clear_o
);

    localparam int unsigned RW = $clog2(MACHINE_TICKS + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(MACHINE_TICKS);
    localparam logic [RW-1:0] PULSE_W = RW'(PULSE_TICKS);
    localparam logic [RW-1:0] CYCLE_W = RW'(MACHINE_TICKS - 1);

    // consecutive high samples of the clear output before this edge
    logic [RW-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= '0;
        end else if (reg_clear_o) begin
            run_q <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    generate
        if (DELAY_TICKS == 1) begin : g_cause
            AST_CLEAR_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
                $rose(reg_clear_o) |-> ($past(gate_level_i && cycle_state_i) && $past(read_trig_i, 2))); // R1
        end
    endgenerate

    AST_PULSE_NOT_LONG: assert property (@(posedge clk_i) disable iff (rst_i)
        reg_clear_o |-> (run_q < PULSE_W)); // R4

    AST_PULSE_NOT_SHORT: assert property (@(posedge clk_i) disable iff (rst_i)
        ((run_q != '0) && (run_q < PULSE_W)) |-> reg_clear_o); // R4

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> !reg_clear_o); // R7

    AST_INSIDE_MACHINE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        reg_clear_o |-> (run_q < CYCLE_W)); // R8

endmodule

bind gsr_clear_pulse gsr_clear_pulse_chk #(
    .DELAY_TICKS   (DELAY_TICKS),
    .PULSE_TICKS   (PULSE_TICKS),
    .MACHINE_TICKS (MACHINE_TICKS)
) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .gate_level_i  (gate_level_i),
    .cycle_state_i (cycle_state_i),
    .read_trig_i   (read_trig_i),
    .reg_clear_o   (reg_clear_o)
);

// File: tb/gsr_clear_pulse_test.sv
`timescale 1ns/1ps
module gsr_clear_pulse_test;

    localparam int PULSE = 2;
    localparam int MTICK = 14;

    logic clk = 1'b0;
    logic rst, gate, cyc, trig;
    logic clear;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expectation state
    logic m_trig_d;
    int   m_busy;
    bit   m_need_low;
    logic m_exp;
    int   rises;
    logic last_out;

    always #2.5 clk = ~clk;

    gsr_clear_pulse #(
        .DELAY_TICKS   (1),
        .PULSE_TICKS   (PULSE),
        .MACHINE_TICKS (MTICK)
    ) uut (
        .clk_i         (clk),
        .rst_i         (rst),
        .gate_level_i  (gate),
        .cycle_state_i (cyc),
        .read_trig_i   (trig),
        .reg_clear_o   (clear)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: reg_clear_o=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one tick (called at a falling edge), advance, compare at next falling edge
    task automatic tick(input logic r, input logic g, input logic c, input logic t,
                        input string tag);
        logic cond_now;
        rst  = r;
        gate = g;
        cyc  = c;
        trig = t;
        if (r) begin
            m_trig_d   = 1'b0;
            m_busy     = 0;
            m_need_low = 1'b0;
        end else begin
            cond_now = g & c & m_trig_d;
            if (m_busy > 0) begin
                if (m_busy == 1 && cond_now) m_need_low = 1'b1;
                m_busy--;
            end else if (m_need_low) begin
                if (!cond_now) m_need_low = 1'b0;
            end else if (cond_now) begin
                m_busy = PULSE;
            end
            m_trig_d = t;
        end
        m_exp = (m_busy > 0);
        @(posedge clk);
        @(negedge clk);
        if (clear === 1'b1 && last_out !== 1'b1) rises++;
        last_out = clear;
        chk(clear, m_exp, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, "R1 idle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; gate = 1'b0; cyc = 1'b0; trig = 1'b0;
        m_trig_d = 1'b0; m_busy = 0; m_need_low = 1'b0; rises = 0; last_out = 1'b0;
        @(negedge clk);

        // R7 reset state
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, "R7 reset");
        chk(clear, 1'b0, "R7 reset state");
        idle(3);

        // R2: all inputs rise together; pulse one tick late, 2 ticks long, held -> one pulse
        rises = 0;
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R2 edge n");
        chk(clear, 1'b0, "R2 low after edge n");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R2 edge n+1");
        chk(clear, 1'b1, "R2 high after edge n+1");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R4 second pulse tick");
        chk(clear, 1'b1, "R4 second pulse tick");
        // R5: hold high for many ticks
        for (int i = 0; i < 8; i++) tick(1'b0, 1'b1, 1'b1, 1'b1, "R5 held high");
        chk(clear, 1'b0, "R5 low while held");
        chk_int(rises, 1, "R5 single pulse while held");
        // drop cycle-state once then raise -> new pulse
        tick(1'b0, 1'b1, 1'b0, 1'b1, "R5 drop");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R5 rise again");
        chk(clear, 1'b1, "R5 refire after low");
        chk_int(rises, 2, "R5 second pulse count");
        idle(4);

        // R3: one-tick cycle-state blip on the first trigger tick
        rises = 0;
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R3 blip");
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b0, 1'b1, "R3 after blip");
        idle(3);
        chk_int(rises, 0, "R3 blip suppressed");

        // R4: one-tick condition still gives a full pulse
        rises = 0;
        tick(1'b0, 1'b1, 1'b0, 1'b1, "R4 prime");
        tick(1'b0, 1'b1, 1'b1, 1'b0, "R4 one tick cond");
        chk(clear, 1'b1, "R4 short cond fires");
        tick(1'b0, 1'b0, 1'b0, 1'b0, "R4 short cond hold");
        chk(clear, 1'b1, "R4 short cond length");
        tick(1'b0, 1'b0, 1'b0, 1'b0, "R4 short cond end");
        chk(clear, 1'b0, "R4 short cond end");
        idle(3);

        // R6: condition falls and rises inside the pulse, high at its last tick
        rises = 0;
        tick(1'b0, 1'b1, 1'b0, 1'b1, "R6 prime");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R6 fire");
        tick(1'b0, 1'b1, 1'b0, 1'b1, "R6 dip");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R6 re-rise");
        chk(clear, 1'b0, "R6 no extension");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R6 held");
        chk(clear, 1'b0, "R6 no restart");
        chk_int(rises, 1, "R6 one pulse");
        idle(3);

        // R7: reset mid-pulse, trigger held through reset
        tick(1'b0, 1'b1, 1'b0, 1'b1, "R7 prime");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R7 fire");
        chk(clear, 1'b1, "R7 pulse started");
        tick(1'b1, 1'b1, 1'b1, 1'b1, "R7 reset mid pulse");
        chk(clear, 1'b0, "R7 reset kills pulse");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R7 first after release");
        chk(clear, 1'b0, "R7 delay stage cleared");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R7 second after release");
        chk(clear, 1'b1, "R7 fires after release");
        idle(4);

        // Sweep: cycle-state patterns against a trigger window (R1 R3 R4 R5 R8)
        for (int p = 0; p < 256; p++) begin
            for (int k = 0; k < MTICK; k++) begin
                tick(1'b0, 1'b1, (k < 8) ? p[k] : 1'b0, (k >= 3 && k < 7),
                     "R1 R3 R4 R5 R8 state sweep");
            end
        end

        // Sweep: gating-level patterns with fixed cycle-state (R1 R4 R5 R6)
        for (int p = 0; p < 256; p++) begin
            for (int k = 0; k < MTICK; k++) begin
                tick(1'b0, (k < 8) ? p[k] : 1'b0, (k >= 2 && k < 10), (k >= 1 && k < 5),
                     "R1 R4 R5 R6 gate sweep");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule